// File: doc/BRIEF.md
# Debug Breakpoint Request Controller

This block sits beside a small CPU's fetch path and decides when a debug breakpoint fires. Each fetch address is compared with a 16-bit match register. A hit produces one of two request styles. In tag style, the hit marks the fetched opcode. The mark travels through a modelled three-slot instruction queue, and the request fires when the marked opcode reaches the last slot, before it would execute. In force style, the hit is remembered, and the request fires at the next instruction-complete strobe.

A request goes out on one of two lines. It uses `take_bg` when background entry is permitted and `take_swi`, a software-interrupt fallback, when it is not. The request line stays high until the core acknowledges it. Acknowledging a background request puts the block in the background-active state, and an exit strobe returns it to idle.

The block also holds a control byte. It contains the breakpoint enable, the tag/force select, the background enable and a clock select. Read-only status bits sit alongside them: the background-active flag plus registered copies of the core's wait, stop and data-valid indications. The block enforces the write rules on these bits.

The controller has four states:
- IDLE is the only state that arms new breakpoints. A trigger moves it to REQ_BG when background is enabled, or to REQ_SWI when it is not.
- REQ_BG moves to BG_ACTIVE on `bg_ack`.
- REQ_SWI moves back to IDLE on `bg_ack`.
- BG_ACTIVE moves back to IDLE on `bg_exit`.

Top module: `bkpt_req_ctl`

## Requirements
- R1: After reset, the match register, every control bit, the background-active flag and both request outputs read 0.
- R2: While the breakpoint enable (control bit 0) is 0, no match ever raises `take_bg` or `take_swi`.
- R3: With tag select (control bit 1) at 1, a fetch is accepted when `fetch_valid` and `instr_done` are both high. An accepted fetch whose address equals the match register is tagged into slot 0. Each later `instr_done` moves it one slot along. The clock edge after the tagged opcode reaches slot 2 raises the request.
- R4: With tag select at 0, a matching accepted fetch sets a pending force. The request rises at the first later clock edge where `instr_done` is high.
- R5: When a breakpoint fires with background enable (control bit 2) at 0, `take_swi` rises instead of `take_bg`. The two outputs are never high together.
- R6: A raised request stays high until `bg_ack`. Acknowledging `take_bg` sets the background-active flag (read bit 4), and `bg_exit` clears it. Acknowledging `take_swi` returns the block to idle with the flag still 0.
- R7: A write to background enable is dropped while the background-active flag is 1.
- R8: Read bits 7:4 are status and ignore writes. Bit 4 is background-active. Bits 5, 6 and 7 show `core_wait`, `core_stop` and `data_valid` one clock after they are sampled.
- R9: The clock select (control bit 3) takes every write, including writes made while background is active.
- R10: `pipe_flush` empties the queue, so a tagged opcode that is flushed never raises a request.
- R11: The match register is written as 16 bits and read back unchanged. A fetch address that differs from it in any bit does not match.
- R12: While a request is pending or background is active, matching fetches are neither tagged nor recorded as pending forces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control and status readback |
| addr_wr | input | 1 | Match register write strobe |
| addr_wdata | input | 16 | Match register write data |
| addr_rdata | output | 16 | Match register readback |
| fetch_valid | input | 1 | A fetched opcode is offered to the queue |
| fetch_addr | input | 16 | Address of the offered opcode |
| instr_done | input | 1 | Instruction complete; the queue advances |
| pipe_flush | input | 1 | Empties the instruction queue |
| bg_ack | input | 1 | Core accepts the raised request |
| bg_exit | input | 1 | Core leaves background mode |
| core_wait | input | 1 | Core wait indication |
| core_stop | input | 1 | Core stop indication |
| data_valid | input | 1 | Debug data valid indication |
| take_bg | output | 1 | Request for background entry |
| take_swi | output | 1 | Request for the software-interrupt fallback |

## Verification
On every cycle the checker confirms four things:
- The two request lines are never high together, and a raised request holds until it is acknowledged.
- The background-active flag rises only from an acknowledged background request.
- Background enable does not move while that flag is set.
- Any new request was preceded by an enabled breakpoint, and a software-interrupt request only by a cleared background enable.

Only the bench scenarios can show the exact fire cycle of a tag as it travels through the queue, the boundary-wait of a force, the loss of tags on flush, exact address comparison, and the suppression of matches while busy.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REQ_BG    = 2'd1,
        ST_REQ_SWI   = 2'd2,
        ST_BG_ACTIVE = 2'd3
    } bkpt_state_e;

    typedef struct packed {
        logic clk_sel;
        logic bg_en;
        logic tag_sel;
        logic brk_en;
    } bkpt_ctl_t;

    localparam int CTL_W       = 8;
    localparam int B_BRK_EN    = 0;
    localparam int B_TAG_SEL   = 1;
    localparam int B_BG_EN     = 2;
    localparam int B_CLK_SEL   = 3;

endpackage

// File: rtl/bkpt_ctl_regs.sv
module bkpt_ctl_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              bg_active,
    input  logic              core_wait,
    input  logic              core_stop,
    input  logic              data_valid,
    output bkpt_ctl_t         ctl,
    output logic [ADDR_W-1:0] match_addr,
    output logic [CTL_W-1:0]  ctl_rdata
);

    logic [2:0] status_q;
    logic       unused_ro_bits;

    // Status bits of the write data have no destination.
    assign unused_ro_bits = ^ctl_wdata[CTL_W-1:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (ctl_wr) begin
            ctl.brk_en  <= ctl_wdata[B_BRK_EN];
            ctl.tag_sel <= ctl_wdata[B_TAG_SEL];
            ctl.clk_sel <= ctl_wdata[B_CLK_SEL];
            if (!bg_active) begin
                ctl.bg_en <= ctl_wdata[B_BG_EN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_addr <= '0;
        end else if (addr_wr) begin
            match_addr <= addr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= {data_valid, core_stop, core_wait};
        end
    end

    assign ctl_rdata = {status_q, bg_active, ctl.clk_sel, ctl.bg_en,
                        ctl.tag_sel, ctl.brk_en};

endmodule

// File: rtl/bkpt_tag_queue.sv
module bkpt_tag_queue #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic in_valid,
    input  logic in_tag,
    output logic head_valid,
    output logic head_tag
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] slot_v;
    logic [DEPTH-1:0] slot_t;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic nxt_v;
        logic nxt_t;
        if (g == 0) begin : g_entry
            assign nxt_v = in_valid;
            assign nxt_t = in_valid & in_tag;
        end else begin : g_shift
            assign nxt_v = slot_v[g-1];
            assign nxt_t = slot_t[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_v[g] <= 1'b0;
                slot_t[g] <= 1'b0;
            end else if (clear) begin
                slot_v[g] <= 1'b0;
                slot_t[g] <= 1'b0;
            end else if (advance) begin
                slot_v[g] <= nxt_v;
                slot_t[g] <= nxt_t;
            end
        end
    end

    assign head_valid = slot_v[LAST];
    assign head_tag   = slot_t[LAST];

endmodule

// File: rtl/bkpt_fsm.sv
module bkpt_fsm
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_en,
    input  logic bg_en,
    input  logic head_tagged,
    input  logic force_hit,
    input  logic instr_done,
    input  logic bg_ack,
    input  logic bg_exit,
    output logic trig,
    output logic accept,
    output logic take_bg,
    output logic take_swi,
    output logic bg_active
);

    bkpt_state_e st_q, st_d;
    logic        force_pend;

    assign trig = (st_q == ST_IDLE) && brk_en &&
                  (head_tagged || (force_pend && instr_done));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_pend <= 1'b0;
        end else if (trig) begin
            force_pend <= 1'b0;
        end else if (force_hit) begin
            force_pend <= 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (trig) begin
                    st_d = bg_en ? ST_REQ_BG : ST_REQ_SWI;
                end
            end
            ST_REQ_BG: begin
                if (bg_ack) begin
                    st_d = ST_BG_ACTIVE;
                end
            end
            ST_REQ_SWI: begin
                if (bg_ack) begin
                    st_d = ST_IDLE;
                end
            end
            ST_BG_ACTIVE: begin
                if (bg_exit) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take_bg   = 1'b0;
        take_swi  = 1'b0;
        bg_active = 1'b0;
        accept    = 1'b0;
        unique case (st_q)
            ST_IDLE:      accept    = 1'b1;
            ST_REQ_BG:    take_bg   = 1'b1;
            ST_REQ_SWI:   take_swi  = 1'b1;
            ST_BG_ACTIVE: bg_active = 1'b1;
            default:      accept    = 1'b0;
        endcase
    end

endmodule

// File: rtl/bkpt_req_ctl.sv
module bkpt_req_ctl
    import bkpt_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int Q_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] addr_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              instr_done,
    input  logic              pipe_flush,
    input  logic              bg_ack,
    input  logic              bg_exit,
    input  logic              core_wait,
    input  logic              core_stop,
    input  logic              data_valid,
    output logic              take_bg,
    output logic              take_swi
);

    bkpt_ctl_t         ctl;
    logic [ADDR_W-1:0] match_addr;
    logic              bg_active;
    logic              trig;
    logic              accept;
    logic              head_valid;
    logic              head_tag;
    logic              hit;
    logic              armed_hit;

    assign hit       = fetch_valid && instr_done && (fetch_addr == match_addr);
    assign armed_hit = hit && ctl.brk_en && accept;
    assign addr_rdata = match_addr;

    bkpt_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .bg_active  (bg_active),
        .core_wait  (core_wait),
        .core_stop  (core_stop),
        .data_valid (data_valid),
        .ctl        (ctl),
        .match_addr (match_addr),
        .ctl_rdata  (ctl_rdata)
    );

    bkpt_tag_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pipe_flush || trig),
        .advance    (instr_done),
        .in_valid   (fetch_valid),
        .in_tag     (armed_hit && ctl.tag_sel),
        .head_valid (head_valid),
        .head_tag   (head_tag)
    );

    bkpt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_en      (ctl.brk_en),
        .bg_en       (ctl.bg_en),
        .head_tagged (head_valid && head_tag),
        .force_hit   (armed_hit && !ctl.tag_sel),
        .instr_done  (instr_done),
        .bg_ack      (bg_ack),
        .bg_exit     (bg_exit),
        .trig        (trig),
        .accept      (accept),
        .take_bg     (take_bg),
        .take_swi    (take_swi),
        .bg_active   (bg_active)
    );

endmodule

// File: rtl/bkpt_req_chk.sv
module bkpt_req_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       take_bg,
    input logic       take_swi,
    input logic       bg_ack,
    input logic [7:0] ctl_rdata
);

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_bg, take_swi}));

    p_hold_bg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bg && !bg_ack) |=> take_bg);

    p_hold_swi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_swi && !bg_ack) |=> take_swi);

    p_active_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[4]) |-> $past(take_bg && bg_ack));

    p_need_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_bg || take_swi) |-> $past(ctl_rdata[0]));

    p_swi_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_swi) |-> !$past(ctl_rdata[2]));

    p_bgen_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |=> (ctl_rdata[2] == $past(ctl_rdata[2])));

endmodule

bind bkpt_req_ctl bkpt_req_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_bg   (take_bg),
    .take_swi  (take_swi),
    .bg_ack    (bg_ack),
    .ctl_rdata (ctl_rdata)
);

// File: tb/sim_bkpt_req_ctl.sv
`timescale 1ns/1ps
module sim_bkpt_req_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, addr_wr = 0, fetch_valid = 0, instr_done = 0;
    logic        pipe_flush = 0, bg_ack = 0, bg_exit = 0;
    logic        core_wait = 0, core_stop = 0, data_valid = 0;
    logic [7:0]  ctl_wdata = 0;
    logic [15:0] addr_wdata = 0, fetch_addr = 0;
    logic [7:0]  ctl_rdata;
    logic [15:0] addr_rdata;
    logic        take_bg, take_swi;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model: st 0 idle, 1 req_bg, 2 req_swi, 3 bg_active
    int          m_st = 0;
    bit [2:0]    m_qv = 0, m_qt = 0;
    bit          m_fp = 0;
    bit [3:0]    m_ctl = 0;
    bit [15:0]   m_addr = 0;
    bit [2:0]    m_stat = 0;

    always #5 clk = ~clk;

    bkpt_req_ctl u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_rdata();
        return {m_stat, (m_st == 3), m_ctl};
    endfunction

    task automatic idle_in();
        ctl_wr = 0; addr_wr = 0; fetch_valid = 0; instr_done = 0;
        pipe_flush = 0; bg_ack = 0; bg_exit = 0;
    endtask

    // compute model next state, take one clock, compare at the following negedge
    task automatic cyc();
        int       n_st;
        bit [2:0] n_qv, n_qt;
        bit       n_fp, trig, hit, arm;
        n_st = m_st; n_qv = m_qv; n_qt = m_qt; n_fp = m_fp;
        trig = (m_st == 0) && m_ctl[0] && ((m_qv[2] && m_qt[2]) || (m_fp && instr_done));
        hit  = fetch_valid && instr_done && (fetch_addr == m_addr);
        arm  = hit && m_ctl[0] && (m_st == 0);
        if (pipe_flush || trig) begin n_qv = 0; n_qt = 0; end
        else if (instr_done) begin
            n_qv = {m_qv[1:0], fetch_valid};
            n_qt = {m_qt[1:0], fetch_valid && arm && m_ctl[1]};
        end
        if (trig) n_fp = 0;
        else if (arm && !m_ctl[1]) n_fp = 1;
        case (m_st)
            0: if (trig) n_st = m_ctl[2] ? 1 : 2;
            1: if (bg_ack) n_st = 3;
            2: if (bg_ack) n_st = 0;
            default: if (bg_exit) n_st = 0;
        endcase
        if (ctl_wr) begin
            m_ctl[0] = ctl_wdata[0]; m_ctl[1] = ctl_wdata[1]; m_ctl[3] = ctl_wdata[3];
            if (m_st != 3) m_ctl[2] = ctl_wdata[2];
        end
        if (addr_wr) m_addr = addr_wdata;
        m_stat = {data_valid, core_stop, core_wait};
        m_st = n_st; m_qv = n_qv; m_qt = n_qt; m_fp = n_fp;
        @(posedge clk);
        @(negedge clk);
        chk("R5 take_bg", take_bg, m_st == 1);
        chk("R5 take_swi", take_swi, m_st == 2);
        chk("R8 ctl_rdata", ctl_rdata, m_rdata());
        chk("R11 addr_rdata", addr_rdata, m_addr);
        idle_in();
    endtask

    task automatic wr_ctl(bit [7:0] d);
        ctl_wr = 1; ctl_wdata = d; cyc();
    endtask

    task automatic advance(bit fv, bit [15:0] a);
        instr_done = 1; fetch_valid = fv; fetch_addr = a; cyc();
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 take_bg", take_bg, 0);
        chk("R1 take_swi", take_swi, 0);
        chk("R1 ctl_rdata", ctl_rdata, 8'h00);
        chk("R1 addr_rdata", addr_rdata, 16'h0000);
        rst_n = 1;
        @(negedge clk);

        // R11 match register write/readback
        addr_wr = 1; addr_wdata = 16'h1234; cyc();
        chk("R11 readback", addr_rdata, 16'h1234);

        // R2 disabled: tag+bg enable but brk_en 0
        wr_ctl(8'h06);
        advance(1, 16'h1234);
        repeat (4) advance(1, 16'h0000);
        chk("R2 no request", {take_bg, take_swi}, 2'b00);

        // R3 tag timing
        wr_ctl(8'h07);
        advance(1, 16'h1234);
        advance(1, 16'h0001);
        advance(1, 16'h0002);
        chk("R3 not yet", take_bg, 0);
        cyc();
        chk("R3 fires", take_bg, 1);
        // R6 hold and R12 matches ignored while pending
        advance(1, 16'h1234);
        advance(1, 16'h1234);
        chk("R6 held", take_bg, 1);
        bg_ack = 1; cyc();
        chk("R6 active flag", ctl_rdata[4], 1);
        chk("R6 request dropped", take_bg, 0);
        // R7 bg_en write dropped, R9 clk_sel taken
        wr_ctl(8'h0B);
        chk("R7 bg_en kept", ctl_rdata[2], 1);
        chk("R9 clk_sel", ctl_rdata[3], 1);
        advance(1, 16'h1234);
        bg_exit = 1; cyc();
        chk("R6 exit", ctl_rdata[4], 0);
        repeat (4) advance(1, 16'h0000);
        chk("R12 no late request", {take_bg, take_swi}, 2'b00);

        // R11 near miss
        advance(1, 16'h1235);
        repeat (4) advance(1, 16'h0000);
        chk("R11 near miss", {take_bg, take_swi}, 2'b00);

        // R10 flush drops a tag
        wr_ctl(8'h07);
        advance(1, 16'h1234);
        pipe_flush = 1; cyc();
        repeat (4) advance(1, 16'h0000);
        chk("R10 flushed tag", {take_bg, take_swi}, 2'b00);

        // R4 force with R5 software interrupt fallback
        wr_ctl(8'h01);
        advance(1, 16'h1234);
        chk("R4 waits", take_swi, 0);
        cyc();
        chk("R4 no boundary yet", take_swi, 0);
        advance(0, 16'h0000);
        chk("R5 swi", take_swi, 1);
        chk("R5 not bg", take_bg, 0);
        bg_ack = 1; cyc();
        chk("R6 swi ack idle", {take_swi, ctl_rdata[4]}, 2'b00);

        // R8 status read-only and mirrored
        wr_ctl(8'hF0);
        chk("R8 ro bits", ctl_rdata[7:4], 4'h0);
        core_stop = 1; cyc();
        chk("R8 stop mirror", ctl_rdata[6], 1);
        core_stop = 0;

        // constrained random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            ctl_wr      = (r[5:0] == 0);
            ctl_wdata   = 8'($urandom);
            if (r[11:6] == 0) ctl_wdata[0] = 1;
            addr_wr     = (r[13:6] == 0);
            addr_wdata  = 16'($urandom);
            instr_done  = r[14];
            fetch_valid = r[15] | r[16];
            fetch_addr  = (r[18:17] == 0) ? m_addr : 16'($urandom);
            pipe_flush  = (r[23:19] == 0);
            bg_ack      = (r[25:24] == 0);
            bg_exit     = (r[28:26] == 0);
            core_wait   = r[29];
            core_stop   = r[30];
            data_valid  = r[31];
            if (i == 100) begin ctl_wr = 1; ctl_wdata = 8'h07; end
            cyc();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule